// File: doc/BRIEF.md
# Reloading Alarm Down-Counter with Interrupt

This block is a programmable alarm timer built around a 16-bit down-counter. On every clock cycle in which the tick-enable input is high, the counter steps down by one. When a tick arrives while the count is already zero, the block treats this as an alarm event. It reloads the counter from a separate preset register that software writes, and it raises a sticky status flag.

Software reaches the timer through a plain single-port register interface. The interface has a write strobe, a word address, write data and combinational read data. The count and the preset are read/write registers. The status flag and the interrupt enable can never be written directly. Each is changed only by writing a 1 to its own set strobe register or its own clear strobe register. Each can be read back through a read-only view. The interrupt request output is the status flag gated by the enable, so software can also force an interrupt by setting the flag itself.

The asynchronous active-low reset is released through a small synchronizer inside the block.

Top module: `atmr_alarm_timer`

## Requirements
- R1: After reset the count, preset, status flag and enable bit are all 0, `irq_o` is 0, and every register offset reads back 0.
- R2: The count register (byte offset 0x00) and the preset register (offset 0x04) are written from `wdata_i[15:0]` and read back in `rdata_o[15:0]`, with `rdata_o[31:16]` reading 0. Address bits [1:0] are ignored, and the register index is taken from `addr_i[4:2]`.
- R3: On a cycle with `tick_i` high, no count write and a nonzero count, the count drops by exactly one. Without a tick or a count write, the count holds.
- R4: On a cycle with `tick_i` high and the count equal to 0 (the alarm event), the count becomes the current preset value instead of decrementing, and the status flag becomes 1.
- R5: A software write to the count register wins over a decrement or reload in the same cycle. The count then takes the written value.
- R6: Writing a value with bit 0 set to offset 0x0C sets the enable bit. Writing a value with bit 0 set to offset 0x08 clears it. Writes to either offset with bit 0 clear leave the enable unchanged. If both strobes are active together, clear wins.
- R7: Writing a value with bit 0 set to offset 0x1C sets the status flag. Writing a value with bit 0 set to offset 0x18 clears it. Writes to either offset with bit 0 clear leave the flag unchanged.
- R8: When an alarm event and a status-clear write fall in the same cycle, the status flag ends up 1.
- R9: The status flag reads at offset 0x10, bit 0, and the enable reads at offset 0x14, bit 0. Writes to these two offsets change neither bit.
- R10: The four strobe offsets (0x08, 0x0C, 0x18, 0x1C) always read 0.
- R11: `irq_o` is 1 exactly when the status flag and the enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count enable, sampled each cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | Interrupt request (status AND enable) |

## Verification
The assertions take for granted that the register port carries at most one access per cycle. A simultaneous enable set and clear therefore cannot arise from the port, and the clear-wins rule is checked only as a property of the flag logic. They also assume that `tick_i` and the write inputs are steady around each rising edge. The bench drives every input on the falling edge and samples read data just after it. It holds `tick_i` low during register traffic, except in the two scenarios that deliberately collide a tick with a count write or with a status clear.

// File: rtl/atmr_pkg.sv
package atmr_pkg;

  localparam int unsigned REG_IDX_W = 3;
  localparam int unsigned REG_NUM   = 1 << REG_IDX_W;
  localparam int unsigned IDX_LSB   = 2;

  typedef enum logic [REG_IDX_W-1:0] {
    RIDX_COUNT  = 3'd0,
    RIDX_PRESET = 3'd1,
    RIDX_EN_CLR = 3'd2,
    RIDX_EN_SET = 3'd3,
    RIDX_STATUS = 3'd4,
    RIDX_ENABLE = 3'd5,
    RIDX_ST_CLR = 3'd6,
    RIDX_ST_SET = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic cnt_wr;
    logic pre_wr;
    logic en_clr;
    logic en_set;
    logic st_clr;
    logic st_set;
  } wr_strb_t;

endpackage

// File: rtl/atmr_rst_sync.sv
module atmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/atmr_regdec.sv
module atmr_regdec
  import atmr_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  cnt_q_i,
  input  logic [CNT_W-1:0]  pre_q_i,
  input  logic              stat_q_i,
  input  logic              en_q_i,
  output wr_strb_t          strb_o,
  output logic [DATA_W-1:0] rdata_o
);

  reg_idx_e           idx;
  logic [REG_NUM-1:0] sel;

  assign idx = reg_idx_e'(addr_i[IDX_LSB +: REG_IDX_W]);

  // One select line per register slot
  for (genvar g = 0; g < REG_NUM; g++) begin : g_sel
    assign sel[g] = wr_en_i && (idx == reg_idx_e'(g));
  end

  always_comb begin
    strb_o        = '0;
    strb_o.cnt_wr = sel[RIDX_COUNT];
    strb_o.pre_wr = sel[RIDX_PRESET];
    strb_o.en_clr = sel[RIDX_EN_CLR] & wdata_i[0];
    strb_o.en_set = sel[RIDX_EN_SET] & wdata_i[0];
    strb_o.st_clr = sel[RIDX_ST_CLR] & wdata_i[0];
    strb_o.st_set = sel[RIDX_ST_SET] & wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    unique case (idx)
      RIDX_COUNT:  rdata_o[CNT_W-1:0] = cnt_q_i;
      RIDX_PRESET: rdata_o[CNT_W-1:0] = pre_q_i;
      RIDX_STATUS: rdata_o[0]         = stat_q_i;
      RIDX_ENABLE: rdata_o[0]         = en_q_i;
      default:     rdata_o            = '0;
    endcase
  end

endmodule

// File: rtl/atmr_counter.sv
module atmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic             pre_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] pre_q_o,
  output logic             zero_evt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pre_q, pre_d;
  logic             cnt_ce, pre_ce;
  logic             at_zero;

  assign at_zero    = (cnt_q == '0);
  assign zero_evt_o = tick_i & at_zero;

  always_comb begin
    cnt_ce = cnt_wr_i | tick_i;
    cnt_d  = cnt_q;
    if (cnt_wr_i) begin
      cnt_d = wdata_i;
    end else if (zero_evt_o) begin
      cnt_d = pre_q;
    end else if (tick_i) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_comb begin
    pre_ce = pre_wr_i;
    pre_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_ce) begin
      pre_q <= pre_d;
    end
  end

  assign cnt_q_o = cnt_q;
  assign pre_q_o = pre_q;

  AST_CNT_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cnt_wr_i) |=> $stable(cnt_q)); // R3
  AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !cnt_wr_i && cnt_q == '0) |=> (cnt_q == $past(pre_q))); // R4
  AST_SW_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> (cnt_q == $past(wdata_i))); // R5

endmodule

// File: rtl/atmr_flags.sv
module atmr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic st_set_i,
  input  logic st_clr_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  output logic stat_q_o,
  output logic en_q_o,
  output logic irq_o
);

  logic stat_q, stat_d, stat_ce;
  logic en_q, en_d, en_ce;

  // Status: any set source beats the clear strobe
  always_comb begin
    stat_ce = evt_i | st_set_i | st_clr_i;
    stat_d  = evt_i | st_set_i;
  end

  // Enable: clear beats set
  always_comb begin
    en_ce = en_set_i | en_clr_i;
    en_d  = en_set_i & ~en_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= 1'b0;
    end else if (stat_ce) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  assign stat_q_o = stat_q;
  assign en_q_o   = en_q;
  assign irq_o    = stat_q & en_q;

  AST_EVT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> stat_q); // R8
  AST_ST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    st_set_i |=> stat_q); // R7
  AST_ST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr_i && !evt_i && !st_set_i) |=> !stat_q); // R7
  AST_ST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!st_clr_i && !evt_i && !st_set_i) |=> $stable(stat_q)); // R7
  AST_EN_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    en_clr_i |=> !en_q); // R6
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_set_i && !en_clr_i) |=> en_q); // R6
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_set_i && !en_clr_i) |=> $stable(en_q)); // R6

endmodule

// File: rtl/atmr_alarm_timer.sv
module atmr_alarm_timer
  import atmr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  logic             rst_sync_n;
  wr_strb_t         strb;
  logic [CNT_W-1:0] cnt_q, pre_q;
  logic             zero_evt;
  logic             stat_q, en_q;

  atmr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  atmr_regdec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regdec (
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .cnt_q_i  (cnt_q),
    .pre_q_i  (pre_q),
    .stat_q_i (stat_q),
    .en_q_i   (en_q),
    .strb_o   (strb),
    .rdata_o  (rdata_o)
  );

  atmr_counter #(.CNT_W(CNT_W)) u_counter (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .tick_i     (tick_i),
    .cnt_wr_i   (strb.cnt_wr),
    .pre_wr_i   (strb.pre_wr),
    .wdata_i    (wdata_i[CNT_W-1:0]),
    .cnt_q_o    (cnt_q),
    .pre_q_o    (pre_q),
    .zero_evt_o (zero_evt)
  );

  atmr_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt_i    (zero_evt),
    .st_set_i (strb.st_set),
    .st_clr_i (strb.st_clr),
    .en_set_i (strb.en_set),
    .en_clr_i (strb.en_clr),
    .stat_q_o (stat_q),
    .en_q_o   (en_q),
    .irq_o    (irq_o)
  );

  AST_RO_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && addr_i[4:2] == 3'd4 && !zero_evt) |=> $stable(stat_q)); // R9
  AST_RO_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && addr_i[4:2] == 3'd5) |=> $stable(en_q)); // R9

endmodule

// File: tb/tb_atmr_alarm_timer.sv
`timescale 1ns/1ps
module tb_atmr_alarm_timer;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic        wr_en_i;
  logic [4:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [4:0] A_CNT = 5'h00, A_PRE = 5'h04, A_ECLR = 5'h08, A_ESET = 5'h0C,
                         A_STAT = 5'h10, A_ENA = 5'h14, A_SCLR = 5'h18, A_SSET = 5'h1C;

  atmr_alarm_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd_check("R1 count", A_CNT, 0);
    rd_check("R1 preset", A_PRE, 0);
    rd_check("R1 status", A_STAT, 0);
    rd_check("R1 enable", A_ENA, 0);
    check("R1 irq", {31'b0, irq_o}, 0);
    rd_check("R10 eclr", A_ECLR, 0);
    rd_check("R10 eset", A_ESET, 0);
    rd_check("R10 sclr", A_SCLR, 0);
    rd_check("R10 sset", A_SSET, 0);
  endtask

  task automatic t_rw;
    wr(A_CNT, 32'hFFFF_1234);
    rd_check("R2 count rw", A_CNT, 32'h0000_1234);
    wr(A_PRE, 32'h5A5A_ABCD);
    rd_check("R2 preset rw", A_PRE, 32'h0000_ABCD);
    rd_check("R2 addr low bits ignored", 5'h07, 32'h0000_ABCD);
  endtask

  task automatic t_decrement;
    wr(A_CNT, 5);
    ticks(3);
    rd_check("R3 decrement", A_CNT, 2);
    repeat (4) @(negedge clk);
    rd_check("R3 hold no tick", A_CNT, 2);
  endtask

  task automatic t_reload;
    wr(A_SCLR, 1);
    wr(A_PRE, 3);
    wr(A_CNT, 1);
    ticks(1);
    rd_check("R4 reach zero", A_CNT, 0);
    rd_check("R4 no flag before event", A_STAT, 0);
    ticks(1);
    rd_check("R4 reload", A_CNT, 3);
    rd_check("R4 status set", A_STAT, 1);
    ticks(1);
    rd_check("R4 count after reload", A_CNT, 2);
  endtask

  task automatic t_precedence;
    wr(A_CNT, 3);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = A_CNT; wdata_i = 32'h40;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    rd_check("R5 write beats decrement", A_CNT, 32'h40);
    wr(A_PRE, 9);
    wr(A_CNT, 0);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = A_CNT; wdata_i = 32'h21;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    rd_check("R5 write beats reload", A_CNT, 32'h21);
  endtask

  task automatic t_enable;
    wr(A_ECLR, 1);
    wr(A_ESET, 2);
    rd_check("R6 set with bit0 clear ignored", A_ENA, 0);
    wr(A_ESET, 1);
    rd_check("R6 enable set", A_ENA, 1);
    wr(A_ECLR, 32'hFFFF_FFFE);
    rd_check("R6 clear with bit0 clear ignored", A_ENA, 1);
    wr(A_ECLR, 1);
    rd_check("R6 enable cleared", A_ENA, 0);
  endtask

  task automatic t_status;
    wr(A_SCLR, 1);
    wr(A_SSET, 0);
    rd_check("R7 set with bit0 clear ignored", A_STAT, 0);
    wr(A_SSET, 1);
    rd_check("R7 status set", A_STAT, 1);
    wr(A_SCLR, 0);
    rd_check("R7 clear with bit0 clear ignored", A_STAT, 1);
    wr(A_SCLR, 1);
    rd_check("R7 status cleared", A_STAT, 0);
  endtask

  task automatic t_race;
    wr(A_PRE, 7);
    wr(A_CNT, 0);
    wr(A_SCLR, 1);
    @(negedge clk);
    tick_i = 1'b1; wr_en_i = 1'b1; addr_i = A_SCLR; wdata_i = 1;
    @(negedge clk);
    tick_i = 1'b0; wr_en_i = 1'b0;
    rd_check("R8 event beats clear", A_STAT, 1);
    rd_check("R8 reload during race", A_CNT, 7);
  endtask

  task automatic t_readonly;
    wr(A_SSET, 1);
    wr(A_ECLR, 1);
    wr(A_STAT, 0);
    rd_check("R9 status write ignored", A_STAT, 1);
    wr(A_ENA, 32'hFFFF);
    rd_check("R9 enable write ignored", A_ENA, 0);
  endtask

  task automatic t_irq;
    wr(A_SCLR, 1); wr(A_ECLR, 1);
    @(negedge clk); check("R11 irq s0 e0", {31'b0, irq_o}, 0);
    wr(A_SSET, 1);
    @(negedge clk); check("R11 irq s1 e0", {31'b0, irq_o}, 0);
    wr(A_ESET, 1);
    @(negedge clk); check("R11 irq s1 e1", {31'b0, irq_o}, 1);
    wr(A_SCLR, 1);
    @(negedge clk); check("R11 irq s0 e1", {31'b0, irq_o}, 0);
    wr(A_CNT, 0);
    ticks(1);
    check("R11 irq from alarm event", {31'b0, irq_o}, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_i = 1'b0; wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_rw;
    t_decrement;
    t_reload;
    t_precedence;
    t_enable;
    t_status;
    t_race;
    t_readonly;
    t_irq;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule